// File: doc/BRIEF.md
# Fractional-Scaled Quadrature Position Accumulator

This block turns a pair of already-synchronized quadrature lines into counting steps at four steps per line cycle, and sums a signed position from them. A step does not add one. It adds or subtracts a programmable fixed-point scale word. That word holds a signed integer part in its upper half and an unsigned fraction in its lower half. The fraction is counted against one of two moduli: 65536 in binary mode or 10000 in decimal mode. A remainder register keeps the part of the position that is below one unit and passes a carry or borrow into the integer position.

The surrounding logic provides three controls. An index-derived clear pulse zeroes the whole position. A host load writes a new integer position. A diagnostic counter reports quadrature transitions in which both lines changed at once. The integer position wraps modulo 2^32.

Top module: `quad_pos_accum`

## Requirements
- R1: After synchronous reset, `pos`, `pos_frac` and `glitch_cnt` are all zero, and the line levels present during reset become the reference state, so that state produces no step.
- R2: The line state is read as the code {enc_a, enc_b}. A change along the cycle 00→01→11→10→00 is a forward step, and it adds the scale word one clock edge after the new levels are sampled. A change along the opposite cycle is a reverse step, and it subtracts the scale word.
- R3: The scale word is split into `scale_const[31:16]` (a signed integer) and `scale_const[15:0]` (the fraction). With `dec_mode` = 0, a forward step adds the fraction to `pos_frac`. When the sum reaches 65536, 65536 is subtracted and one is carried into `pos`.
- R4: With `dec_mode` = 1, the fraction is counted modulo 10000, and the carry into `pos` happens when the sum reaches 10000.
- R5: On a reverse step, when `pos_frac` is smaller than the fraction, the modulus is added back to `pos_frac` and one extra unit is borrowed from `pos`.
- R6: A negative integer part reverses the rotation sense. For example, forward steps with a scale word of 0xFFFF0000 lower `pos` by one each.
- R7: A change in which both lines toggle together leaves `pos` and `pos_frac` unchanged. It raises `glitch_cnt` by one, and the counter saturates at its all-ones value.
- R8: `const_bad` is 1 exactly when `dec_mode` = 1 and the fraction is 10000 or more. While it is 1, the fraction adds nothing and only the integer part is applied.
- R9: `idx_clr` zeroes both `pos` and `pos_frac`. It takes priority over a step and over a host load in the same cycle.
- R10: `host_wr` loads `host_pos` into `pos` and zeroes `pos_frac`. It takes priority over a step in the same cycle.
- R11: `pos` wraps modulo 2^32. For example, 0x7FFFFFFF + 1 gives 0x80000000, and 0xFFFFFFFF + 1 gives 0.
- R12: With unchanged line levels and no clear or load, `pos` and `pos_frac` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Quadrature line A, already synchronized |
| enc_b | input | 1 | Quadrature line B, already synchronized |
| scale_const | input | 32 | Signed integer part [31:16], fraction [15:0] |
| dec_mode | input | 1 | 1 selects fraction modulus 10000, 0 selects 65536 |
| idx_clr | input | 1 | Clear request from the index logic |
| host_wr | input | 1 | Load `host_pos` into the position |
| host_pos | input | 32 | Value for a host load |
| pos | output | 32 | Signed integer position |
| pos_frac | output | 16 | Sub-unit remainder |
| const_bad | output | 1 | Decimal fraction is out of range |
| glitch_cnt | output | 8 | Saturating count of double transitions |

## Verification
The bench builds the block with the error counter narrowed to three bits. At that width, ten double transitions are enough to drive the counter to its saturation value of 7 and hold it there. All other parameters keep their defaults: 32-bit position, 16.16 scale word and a decimal modulus of 10000. With those values the bench reaches both carry moduli and the signed wrap at 0x7FFFFFFF and 0xFFFFFFFF with loaded start positions, in a few dozen cycles.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

    typedef enum logic [1:0] {
        MV_NONE = 2'd0,
        MV_FWD  = 2'd1,
        MV_REV  = 2'd2,
        MV_BAD  = 2'd3
    } move_e;

    // Forward successor of a line code {a,b}: 00 -> 01 -> 11 -> 10 -> 00
    function automatic logic [1:0] gray_succ(input logic [1:0] s);
        case (s)
            2'b00:   gray_succ = 2'b01;
            2'b01:   gray_succ = 2'b11;
            2'b11:   gray_succ = 2'b10;
            default: gray_succ = 2'b00;
        endcase
    endfunction

    function automatic move_e classify(input logic [1:0] prev, input logic [1:0] cur);
        if (cur == prev)                 classify = MV_NONE;
        else if (cur == gray_succ(prev)) classify = MV_FWD;
        else if (prev == gray_succ(cur)) classify = MV_REV;
        else                             classify = MV_BAD;
    endfunction

endpackage

// File: rtl/qpa_quad_decode.sv
module qpa_quad_decode
    import qpa_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  enc_a,
    input  logic  enc_b,
    output move_e move
);
    logic [1:0] prev_q;
    logic [1:0] cur;

    assign cur = {enc_a, enc_b};

    always_ff @(posedge clk) begin
        prev_q <= cur;
    end

    always_comb begin
        move = rst ? MV_NONE : classify(prev_q, cur);
    end
endmodule

// File: rtl/qpa_fix_accum.sv
module qpa_fix_accum
    import qpa_pkg::*;
#(
    parameter int POS_W   = 32,
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 16,
    parameter int DEC_MOD = 10000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  move_e                     move,
    input  logic [INT_W+FRAC_W-1:0]   scale_const,
    input  logic                      dec_mode,
    input  logic                      clr,
    input  logic                      ld,
    input  logic [POS_W-1:0]          ld_val,
    output logic [POS_W-1:0]          pos,
    output logic [FRAC_W-1:0]         rem,
    output logic                      const_bad
);
    localparam int SUM_W = FRAC_W + 1;
    localparam int SC_W  = INT_W + FRAC_W;
    localparam logic [SUM_W-1:0] BIN_M = {1'b1, {FRAC_W{1'b0}}};
    localparam logic [SUM_W-1:0] DEC_M = SUM_W'(DEC_MOD);

    logic [SUM_W-1:0] modv;
    logic [SUM_W-1:0] frac_eff;
    logic [POS_W-1:0] int_ext;
    logic [SUM_W-1:0] fwd_sum;
    logic [SUM_W-1:0] rev_sum;
    logic             carry;
    logic             borrow;
    logic [POS_W-1:0] pos_next;
    logic [FRAC_W-1:0] rem_next;

    always_comb begin
        modv      = dec_mode ? DEC_M : BIN_M;
        const_bad = dec_mode && ({1'b0, scale_const[FRAC_W-1:0]} >= DEC_M);
        frac_eff  = const_bad ? '0 : {1'b0, scale_const[FRAC_W-1:0]};
        int_ext   = {{(POS_W-INT_W){scale_const[SC_W-1]}}, scale_const[SC_W-1:FRAC_W]};

        fwd_sum = {1'b0, rem} + frac_eff;
        carry   = (fwd_sum >= modv);
        if (carry) fwd_sum = fwd_sum - modv;

        borrow  = ({1'b0, rem} < frac_eff);
        rev_sum = borrow ? ({1'b0, rem} + modv - frac_eff) : ({1'b0, rem} - frac_eff);

        pos_next = pos;
        rem_next = rem;
        if (clr) begin
            pos_next = '0;
            rem_next = '0;
        end else if (ld) begin
            pos_next = ld_val;
            rem_next = '0;
        end else if (move == MV_FWD) begin
            pos_next = pos + int_ext + POS_W'(carry);
            rem_next = fwd_sum[FRAC_W-1:0];
        end else if (move == MV_REV) begin
            pos_next = pos - int_ext - POS_W'(borrow);
            rem_next = rev_sum[FRAC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
            rem <= '0;
        end else begin
            pos <= pos_next;
            rem <= rem_next;
        end
    end
endmodule

// File: rtl/qpa_err_count.sv
module qpa_err_count
    import qpa_pkg::*;
#(
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  move_e            move,
    output logic [ERR_W-1:0] cnt
);
    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (move == MV_BAD && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/quad_pos_accum.sv
module quad_pos_accum
    import qpa_pkg::*;
#(
    parameter int POS_W   = 32,
    parameter int INT_W   = 16,
    parameter int FRAC_W  = 16,
    parameter int DEC_MOD = 10000,
    parameter int ERR_W   = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enc_a,
    input  logic                    enc_b,
    input  logic [INT_W+FRAC_W-1:0] scale_const,
    input  logic                    dec_mode,
    input  logic                    idx_clr,
    input  logic                    host_wr,
    input  logic [POS_W-1:0]        host_pos,
    output logic [POS_W-1:0]        pos,
    output logic [FRAC_W-1:0]       pos_frac,
    output logic                    const_bad,
    output logic [ERR_W-1:0]        glitch_cnt
);
    move_e move;

    qpa_quad_decode u_dec (
        .clk   (clk),
        .rst   (rst),
        .enc_a (enc_a),
        .enc_b (enc_b),
        .move  (move)
    );

    qpa_fix_accum #(
        .POS_W   (POS_W),
        .INT_W   (INT_W),
        .FRAC_W  (FRAC_W),
        .DEC_MOD (DEC_MOD)
    ) u_acc (
        .clk         (clk),
        .rst         (rst),
        .move        (move),
        .scale_const (scale_const),
        .dec_mode    (dec_mode),
        .clr         (idx_clr),
        .ld          (host_wr),
        .ld_val      (host_pos),
        .pos         (pos),
        .rem         (pos_frac),
        .const_bad   (const_bad)
    );

    qpa_err_count #(
        .ERR_W (ERR_W)
    ) u_err (
        .clk  (clk),
        .rst  (rst),
        .move (move),
        .cnt  (glitch_cnt)
    );
endmodule

// File: rtl/qpa_checker.sv
module qpa_checker #(
    parameter int POS_W  = 32,
    parameter int FRAC_W = 16,
    parameter int ERR_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              enc_a,
    input logic              enc_b,
    input logic              idx_clr,
    input logic              host_wr,
    input logic [POS_W-1:0]  host_pos,
    input logic [POS_W-1:0]  pos,
    input logic [FRAC_W-1:0] pos_frac,
    input logic [ERR_W-1:0]  glitch_cnt
);
    // R9: a clear leaves a zero position and remainder
    p_clear_zero_r9: assert property (@(posedge clk) disable iff (rst)
        idx_clr |=> (pos == '0 && pos_frac == '0));

    // R10: a load without clear takes the host value and zeroes the remainder
    p_host_load_r10: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !idx_clr) |=> (pos == $past(host_pos) && pos_frac == '0));

    // R7: both lines toggling together leave the position untouched
    p_glitch_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!idx_clr && !host_wr && enc_a != $past(enc_a) && enc_b != $past(enc_b))
        |=> ($stable(pos) && $stable(pos_frac)));

    // R7: the glitch count never goes down
    p_glitch_mono_r7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (glitch_cnt >= $past(glitch_cnt)));

    // R12: steady lines with no clear or load hold the position
    p_idle_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (!idx_clr && !host_wr && $stable(enc_a) && $stable(enc_b))
        |=> ($stable(pos) && $stable(pos_frac)));
endmodule

bind quad_pos_accum qpa_checker #(
    .POS_W  (POS_W),
    .FRAC_W (FRAC_W),
    .ERR_W  (ERR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .enc_a      (enc_a),
    .enc_b      (enc_b),
    .idx_clr    (idx_clr),
    .host_wr    (host_wr),
    .host_pos   (host_pos),
    .pos        (pos),
    .pos_frac   (pos_frac),
    .glitch_cnt (glitch_cnt)
);

// File: tb/quad_pos_accum_tb.sv
`timescale 1ns/1ps
module quad_pos_accum_tb;
    localparam int EW = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic [31:0] scale_const = '0;
    logic        dec_mode = 1'b0;
    logic        idx_clr = 1'b0, host_wr = 1'b0;
    logic [31:0] host_pos = '0;
    logic [31:0] pos;
    logic [15:0] pos_frac;
    logic        const_bad;
    logic [EW-1:0] glitch_cnt;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit started = 0;
    bit done = 0;

    quad_pos_accum #(.ERR_W(EW)) u_dut (
        .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b),
        .scale_const(scale_const), .dec_mode(dec_mode),
        .idx_clr(idx_clr), .host_wr(host_wr), .host_pos(host_pos),
        .pos(pos), .pos_frac(pos_frac), .const_bad(const_bad),
        .glitch_cnt(glitch_cnt)
    );

    always #4 clk = ~clk;

    // ---------------- behavioural reference ----------------
    logic [31:0] m_pos;
    longint      m_rem;
    int          m_err;
    int          m_prev;

    function automatic int ring_idx(input logic [1:0] c);
        case (c)
            2'b00: return 0;
            2'b01: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin
        int cur, d, sgn;
        longint modm, fr, iv, t, r, p;
        shortint si;
        cur = ring_idx({enc_a, enc_b});
        if (rst) begin
            m_pos = '0; m_rem = 0; m_err = 0; m_prev = cur;
        end else begin
            d = (cur - m_prev + 4) % 4;
            m_prev = cur;
            if (d == 2 && m_err < (1 << EW) - 1) m_err = m_err + 1;
            if (idx_clr) begin
                m_pos = '0; m_rem = 0;
            end else if (host_wr) begin
                m_pos = host_pos; m_rem = 0;
            end else if (d == 1 || d == 3) begin
                sgn  = (d == 1) ? 1 : -1;
                modm = dec_mode ? 10000 : 65536;
                fr   = scale_const[15:0];
                if (dec_mode && fr >= 10000) fr = 0;
                si   = scale_const[31:16];
                iv   = si;
                t = longint'($signed(m_pos)) * modm + m_rem + sgn * (iv * modm + fr);
                r = t % modm;
                if (r < 0) r = r + modm;
                p = (t - r) / modm;
                m_pos = p[31:0];
                m_rem = r;
            end
        end
        started = 1;
    end

    always @(negedge clk) begin
        if (started && !done) begin
            checks++;
            if (pos !== m_pos || longint'(pos_frac) != m_rem || int'(glitch_cnt) != m_err) begin
                errors++;
                $display("FAIL %s per-cycle: pos=%h frac=%0d err=%0d expected pos=%h frac=%0d err=%0d",
                         cur_req, pos, pos_frac, glitch_cnt, m_pos, m_rem, m_err);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [1:0] ab = 2'b00;

    function automatic logic [1:0] ring_code(input int i);
        case (i % 4)
            0: return 2'b00;
            1: return 2'b01;
            2: return 2'b11;
            default: return 2'b10;
        endcase
    endfunction

    task automatic cyc(input logic [1:0] n, input logic c, input logic w, input logic [31:0] v);
        @(negedge clk);
        ab = n; enc_a = n[1]; enc_b = n[0];
        idx_clr = c; host_wr = w; host_pos = v;
    endtask

    task automatic fwd(input int n);
        for (int i = 0; i < n; i++) cyc(ring_code(ring_idx(ab) + 1), 0, 0, 0);
    endtask

    task automatic rev(input int n);
        for (int i = 0; i < n; i++) cyc(ring_code(ring_idx(ab) + 3), 0, 0, 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(ab, 0, 0, 0);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle;
        @(posedge clk); #1;
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R1 pos after reset", pos, 0);
        chk("R1 frac after reset", pos_frac, 0);
        chk("R1 glitch count after reset", glitch_cnt, 0);
        idle(2); settle;
        chk("R1 reset levels give no step", pos, 0);

        cur_req = "R2";
        scale_const = 32'h0001_8000; dec_mode = 0;
        fwd(1); settle;
        chk("R2 one forward step pos", pos, 1);
        chk("R3 one forward step frac", pos_frac, 16'h8000);
        fwd(3); settle;
        chk("R3 binary carry pos", pos, 6);
        chk("R3 binary carry frac", pos_frac, 0);
        cur_req = "R5";
        rev(1); settle;
        chk("R5 reverse borrow pos", pos, 4);
        chk("R5 reverse borrow frac", pos_frac, 16'h8000);

        cur_req = "R4";
        cyc(ab, 1, 0, 0); settle;
        chk("R9 clear pos", pos, 0);
        scale_const = 32'h0000_1388; dec_mode = 1;
        fwd(3); settle;
        chk("R4 decimal carry pos", pos, 1);
        chk("R4 decimal carry frac", pos_frac, 5000);
        cur_req = "R5";
        rev(4); settle;
        chk("R5 decimal borrow below zero pos", pos, 32'hFFFF_FFFF);
        chk("R5 decimal borrow frac", pos_frac, 5000);

        cur_req = "R6";
        cyc(ab, 1, 0, 0);
        scale_const = 32'hFFFF_0000; dec_mode = 0;
        fwd(2); settle;
        chk("R6 negative constant reverses sense", pos, 32'hFFFF_FFFE);

        cur_req = "R8";
        cyc(ab, 1, 0, 0);
        scale_const = 32'h0002_2EE0; dec_mode = 1;
        settle;
        chk("R8 const_bad in decimal mode", const_bad, 1);
        fwd(1); settle;
        chk("R8 bad fraction ignored pos", pos, 2);
        chk("R8 bad fraction ignored frac", pos_frac, 0);
        dec_mode = 0; settle;
        chk("R8 const_bad clear in binary mode", const_bad, 0);
        fwd(1); settle;
        chk("R8 binary applies same fraction pos", pos, 4);
        chk("R8 binary applies same fraction frac", pos_frac, 12000);

        cur_req = "R7";
        cyc(ab ^ 2'b11, 0, 0, 0); settle;
        chk("R7 glitch count one", glitch_cnt, 1);
        chk("R7 glitch leaves pos", pos, 4);
        for (int i = 0; i < 9; i++) cyc(ab ^ 2'b11, 0, 0, 0);
        settle;
        chk("R7 glitch count saturates", glitch_cnt, 7);
        chk("R7 glitches leave frac", pos_frac, 12000);

        cur_req = "R11";
        cyc(ab, 0, 1, 32'h7FFF_FFFF); settle;
        chk("R10 host load pos", pos, 32'h7FFF_FFFF);
        chk("R10 host load zeroes frac", pos_frac, 0);
        scale_const = 32'h0001_0000;
        fwd(1); settle;
        chk("R11 signed wrap", pos, 32'h8000_0000);
        cyc(ab, 0, 1, 32'hFFFF_FFFF);
        fwd(1); settle;
        chk("R11 unsigned wrap", pos, 0);

        cur_req = "R9";
        scale_const = 32'h0001_4000;
        fwd(1);
        cyc(ring_code(ring_idx(ab) + 1), 1, 1, 32'd55); settle;
        chk("R9 clear beats step and load pos", pos, 0);
        chk("R9 clear beats step and load frac", pos_frac, 0);
        cur_req = "R10";
        fwd(1);
        cyc(ring_code(ring_idx(ab) + 1), 0, 1, 32'd100); settle;
        chk("R10 load beats step pos", pos, 100);
        chk("R10 load beats step frac", pos_frac, 0);

        cur_req = "R12";
        idle(5); settle;
        chk("R12 idle holds pos", pos, 100);
        chk("R12 idle holds frac", pos_frac, 0);

        idle(2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        done = 1;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule